// File: doc/BRIEF.md
# Unordered Record Fetch Engine

The engine takes one bulk read request made of a base address, a record size in words and a record count. It reads every word of the region `base .. base + count*size - 1` from a memory port. That port may answer in any order, and each answer carries a tag that the engine chose when it issued the read. Record `i` covers the addresses `base + i*size` up to `base + i*size + size - 1`.

Each record has its own reassembly slot. Several records can be in flight at once, one per slot. A record is streamed out on a valid/ready channel as soon as all of its words have arrived, so a slow first word does not hold back later records that are already complete. Records may therefore leave in any order. Inside one record the words always leave in ascending address order. Each output beat carries the record index, the word index and the data, and it is marked as last on the final word of its record. A one-cycle done pulse closes the request, and only after that pulse does the engine accept a new request.

Top module: `urf_engine`

## Requirements
- R1: After reset `req_ready_o` is 1, and `out_valid_o`, `mem_req_valid_o` and `done_o` are 0.
- R2: A request is taken on a cycle where `req_valid_i` and `req_ready_o` are both 1. From the next cycle `req_ready_o` stays 0 until the cycle in which `done_o` is high. The caller keeps `req_size_i` within 1..MAX_WORDS.
- R3: Every word of the region is read exactly once, at addresses that ascend by one from `base` to `base + count*size - 1`. The tag splits into two fields: the upper SLOT_W bits hold the slot, and the low WIDX_W bits hold the word index `(addr - base) mod size`. Every record index `0..count-1` is delivered exactly once.
- R4: The beats of a record carry word indices 0, 1, ..., size-1 in that order. The data of each beat equals the memory word at `base + rec*size + word`, and `out_last_o` is 1 exactly on the beat with word index size-1.
- R5: A record whose words have all arrived is output without waiting for records at lower addresses. If record 0 is slow, a later record leaves first.
- R6: Once the first beat of a record has been taken, every beat up to its last beat belongs to that same record. The cycle after a last beat is taken carries no valid beat.
- R7: At most SLOTS records are in flight. If no responses return, the engine issues exactly SLOTS*size reads and then stops.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the beat holds all of its fields stable. Reads keep being issued into free slots while the output is stalled.
- R9: `done_o` is high for the single cycle after the final beat of the request is taken. A request with a count of zero issues no reads and raises `done_o` in the cycle after it is accepted.
- R10: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the read stays valid and its address and tag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle, request can be taken |
| req_base_i | input | ADDR_W | Address of word 0 of record 0 |
| req_size_i | input | SIZE_W | Words per record, 1..MAX_WORDS |
| req_count_i | input | CNT_W | Number of records |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory takes the read |
| mem_req_addr_o | output | ADDR_W | Read address |
| mem_req_tag_o | output | SLOT_W+WIDX_W | Read tag: {slot, word index} |
| mem_rsp_valid_i | input | 1 | Read response valid, always accepted |
| mem_rsp_tag_i | input | SLOT_W+WIDX_W | Tag of the read being answered |
| mem_rsp_data_i | input | DATA_W | Response data |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Consumer takes the beat |
| out_rec_o | output | CNT_W | Record index of the beat |
| out_word_o | output | WIDX_W | Word index within the record |
| out_data_o | output | DATA_W | Word data |
| out_last_o | output | 1 | Final word of the record |
| done_o | output | 1 | One-cycle pulse when the request is complete |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- a stalled beat and a stalled read hold steady;
- the word index steps by one inside a record and starts at zero;
- a record never interleaves with another;
- the engine refuses requests while it is busy;
- done only follows a final beat or an empty request.

Only the bench scenarios can show the other properties. These are that every address is read once, that the data matches memory, and that every record arrives exactly once. They also include that a record completed early overtakes a slow record 0, that issue stops at the slot limit when responses are withheld, and that issue continues while the output is stalled.

// File: rtl/urf_pkg.sv
package urf_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/urf_issue.sv
module urf_issue #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_WORDS = 16,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned WIDX_W   = $clog2(MAX_WORDS),
  localparam int unsigned SIZE_W   = $clog2(MAX_WORDS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [SIZE_W-1:0]        size_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [SLOTS-1:0]         free_i,
  output logic                     alloc_o,
  output logic [SLOT_W-1:0]        alloc_slot_o,
  output logic [CNT_W-1:0]         alloc_rec_o,
  output logic                     mem_req_valid_o,
  input  logic                     mem_req_ready_i,
  output logic [ADDR_W-1:0]        mem_req_addr_o,
  output logic [SLOT_W+WIDX_W-1:0] mem_req_tag_o
);
  logic              active_q, pending_q, any_free, last_word;
  logic [SLOT_W-1:0] slot_q, pick;
  logic [WIDX_W-1:0] word_q;
  logic [CNT_W-1:0]  rec_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    pick     = '0;
    any_free = 1'b0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (free_i[s]) begin
        pick     = SLOT_W'(s);
        any_free = 1'b1;
      end
    end
  end

  assign alloc_o         = pending_q && !active_q && any_free;
  assign alloc_slot_o    = pick;
  assign alloc_rec_o     = rec_q;
  assign last_word       = word_q == WIDX_W'(size_i - SIZE_W'(1));
  assign mem_req_valid_o = active_q;
  assign mem_req_addr_o  = addr_q;
  assign mem_req_tag_o   = {slot_q, word_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      pending_q <= 1'b0;
      slot_q    <= '0;
      word_q    <= '0;
      rec_q     <= '0;
      addr_q    <= '0;
    end else if (start_i) begin
      addr_q    <= base_i;
      rec_q     <= '0;
      pending_q <= 1'b1;
      active_q  <= 1'b0;
    end else if (alloc_o) begin
      active_q <= 1'b1;
      slot_q   <= pick;
      word_q   <= '0;
    end else if (active_q && mem_req_ready_i) begin
      addr_q <= addr_q + ADDR_W'(1);
      if (last_word) begin
        active_q  <= 1'b0;
        rec_q     <= rec_q + CNT_W'(1);
        pending_q <= (rec_q + CNT_W'(1)) != count_i;
      end else begin
        word_q <= word_q + WIDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/urf_slots.sv
module urf_slots #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_WORDS = 16,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned WIDX_W   = $clog2(MAX_WORDS),
  localparam int unsigned SIZE_W   = $clog2(MAX_WORDS + 1),
  localparam int unsigned TAG_W    = SLOT_W + WIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              alloc_i,
  input  logic [SLOT_W-1:0] alloc_slot_i,
  input  logic [CNT_W-1:0]  alloc_rec_i,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              rel_i,
  input  logic [SLOT_W-1:0] rel_slot_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [WIDX_W-1:0] rd_word_i,
  output logic [SLOTS-1:0]  free_o,
  output logic [SLOTS-1:0]  full_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  rd_rec_o
);
  logic [MAX_WORDS-1:0]          need;
  logic [SLOTS-1:0][DATA_W-1:0]  slot_word;
  logic [SLOTS-1:0][CNT_W-1:0]   slot_rec;
  logic [SLOT_W-1:0]             rsp_slot;
  logic [WIDX_W-1:0]             rsp_word;

  assign rsp_slot = rsp_tag_i[TAG_W-1:WIDX_W];
  assign rsp_word = rsp_tag_i[WIDX_W-1:0];

  always_comb begin
    for (int k = 0; k < int'(MAX_WORDS); k++) need[k] = k < int'(size_i);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic                 used_q, hit_alloc, hit_rsp, hit_rel;
    logic [MAX_WORDS-1:0] have_q;
    logic [CNT_W-1:0]     rec_q;
    logic [DATA_W-1:0]    words_q [MAX_WORDS];

    assign hit_alloc = alloc_i && (alloc_slot_i == SLOT_W'(s));
    assign hit_rsp   = rsp_valid_i && (rsp_slot == SLOT_W'(s));
    assign hit_rel   = rel_i && (rel_slot_i == SLOT_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        used_q <= 1'b0;
        have_q <= '0;
        rec_q  <= '0;
      end else begin
        if (hit_alloc) begin
          used_q <= 1'b1;
          have_q <= '0;
          rec_q  <= alloc_rec_i;
        end else if (hit_rel) begin
          used_q <= 1'b0;
          have_q <= '0;
        end
        if (hit_rsp) have_q[rsp_word] <= 1'b1;
      end
    end

    // payload storage, no reset needed
    always_ff @(posedge clk_i) begin
      if (hit_rsp) words_q[rsp_word] <= rsp_data_i;
    end

    assign free_o[s]    = !used_q;
    assign full_o[s]    = used_q && (have_q == need);
    assign slot_word[s] = words_q[rd_word_i];
    assign slot_rec[s]  = rec_q;
  end

  assign rd_data_o = slot_word[rd_slot_i];
  assign rd_rec_o  = slot_rec[rd_slot_i];
endmodule

// File: rtl/urf_drain.sv
module urf_drain #(
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_WORDS = 16,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned WIDX_W   = $clog2(MAX_WORDS),
  localparam int unsigned SIZE_W   = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOTS-1:0]  full_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              out_ready_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WIDX_W-1:0] word_o,
  output logic              last_o,
  output logic              rel_o
);
  logic              active_q, any_full;
  logic [SLOT_W-1:0] slot_q, pick;
  logic [WIDX_W-1:0] word_q;

  // lowest-numbered complete slot wins
  always_comb begin
    pick     = '0;
    any_full = 1'b0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (full_i[s]) begin
        pick     = SLOT_W'(s);
        any_full = 1'b1;
      end
    end
  end

  assign valid_o = active_q;
  assign slot_o  = slot_q;
  assign word_o  = word_q;
  assign last_o  = word_q == WIDX_W'(size_i - SIZE_W'(1));
  assign rel_o   = active_q && out_ready_i && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      word_q   <= '0;
    end else if (!active_q) begin
      if (any_full) begin
        active_q <= 1'b1;
        slot_q   <= pick;
        word_q   <= '0;
      end
    end else if (out_ready_i) begin
      if (last_o) active_q <= 1'b0;
      else        word_q   <= word_q + WIDX_W'(1);
    end
  end
endmodule

// File: rtl/urf_engine.sv
module urf_engine
  import urf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_WORDS = 16,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned WIDX_W   = $clog2(MAX_WORDS),
  localparam int unsigned SIZE_W   = $clog2(MAX_WORDS + 1),
  localparam int unsigned TAG_W    = SLOT_W + WIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic [CNT_W-1:0]  req_count_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [TAG_W-1:0]  mem_req_tag_o,
  input  logic              mem_rsp_valid_i,
  input  logic [TAG_W-1:0]  mem_rsp_tag_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [CNT_W-1:0]  out_rec_o,
  output logic [WIDX_W-1:0] out_word_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              done_o
);
  eng_state_e        state_q;
  logic [SIZE_W-1:0] size_q;
  logic [CNT_W-1:0]  count_q, out_cnt_q;
  logic              done_q, accept, start;
  logic              alloc, rel;
  logic [SLOT_W-1:0] alloc_slot, drain_slot;
  logic [CNT_W-1:0]  alloc_rec;
  logic [SLOTS-1:0]  slot_free, slot_full;

  assign req_ready_o = state_q == ENG_IDLE;
  assign accept      = req_valid_i && req_ready_o;
  assign start       = accept && (req_count_i != '0);
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ENG_IDLE;
      size_q    <= SIZE_W'(1);
      count_q   <= '0;
      out_cnt_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        size_q    <= req_size_i;
        count_q   <= req_count_i;
        out_cnt_q <= '0;
        if (req_count_i == '0) done_q  <= 1'b1;
        else                   state_q <= ENG_RUN;
      end else if (rel) begin
        out_cnt_q <= out_cnt_q + CNT_W'(1);
        if (out_cnt_q + CNT_W'(1) == count_q) begin
          state_q <= ENG_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  urf_issue #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS)
  ) i_issue (
    .clk_i, .rst_ni,
    .start_i         (start),
    .base_i          (req_base_i),
    .size_i          (size_q),
    .count_i         (count_q),
    .free_i          (slot_free),
    .alloc_o         (alloc),
    .alloc_slot_o    (alloc_slot),
    .alloc_rec_o     (alloc_rec),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_tag_o   (mem_req_tag_o)
  );

  urf_slots #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS)
  ) i_slots (
    .clk_i, .rst_ni,
    .size_i       (size_q),
    .alloc_i      (alloc),
    .alloc_slot_i (alloc_slot),
    .alloc_rec_i  (alloc_rec),
    .rsp_valid_i  (mem_rsp_valid_i),
    .rsp_tag_i    (mem_rsp_tag_i),
    .rsp_data_i   (mem_rsp_data_i),
    .rel_i        (rel),
    .rel_slot_i   (drain_slot),
    .rd_slot_i    (drain_slot),
    .rd_word_i    (out_word_o),
    .free_o       (slot_free),
    .full_o       (slot_full),
    .rd_data_o    (out_data_o),
    .rd_rec_o     (out_rec_o)
  );

  urf_drain #(
    .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS)
  ) i_drain (
    .clk_i, .rst_ni,
    .full_i      (slot_full),
    .size_i      (size_q),
    .out_ready_i (out_ready_i),
    .valid_o     (out_valid_o),
    .slot_o      (drain_slot),
    .word_o      (out_word_o),
    .last_o      (out_last_o),
    .rel_o       (rel)
  );
endmodule

// File: rtl/urf_checks.sv
module urf_checks #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned MAX_WORDS = 16,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned WIDX_W   = $clog2(MAX_WORDS),
  localparam int unsigned SIZE_W   = $clog2(MAX_WORDS + 1),
  localparam int unsigned TAG_W    = SLOT_W + WIDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [SIZE_W-1:0] req_size_i,
  input logic [CNT_W-1:0]  req_count_i,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [TAG_W-1:0]  mem_req_tag_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [CNT_W-1:0]  out_rec_o,
  input logic [WIDX_W-1:0] out_word_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_last_o,
  input logic              done_o
);
  p_size_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |-> (req_size_i != '0) && (req_size_i <= SIZE_W'(MAX_WORDS)));

  p_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o || mem_req_valid_o) |-> !req_ready_o);

  p_first_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_word_o == '0);

  p_word_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_last_o |=>
      out_valid_o && (out_word_o == WIDX_W'($past(out_word_o) + 1'b1)) && (out_rec_o == $past(out_rec_o)));

  p_record_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);

  p_beat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_rec_o)
      && $stable(out_word_o) && $stable(out_last_o));

  p_mem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_tag_o));

  p_done_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_valid_o && out_ready_i && out_last_o)
            || $past(req_valid_i && req_ready_o && (req_count_i == '0)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !(req_valid_i && req_ready_o && (req_count_i == '0)) |=> !done_o);
endmodule

bind urf_engine urf_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS)
) i_urf_checks (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_size_i      (req_size_i),
  .req_count_i     (req_count_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_tag_o   (mem_req_tag_o),
  .out_valid_o     (out_valid_o),
  .out_ready_i     (out_ready_i),
  .out_rec_o       (out_rec_o),
  .out_word_o      (out_word_o),
  .out_data_o      (out_data_o),
  .out_last_o      (out_last_o),
  .done_o          (done_o)
);

// File: tb/test_urf_engine.sv
module test_urf_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, DATA_W = 32, CNT_W = 16, SLOTS = 4, MAX_WORDS = 16;
  localparam int SLOT_W = $clog2(SLOTS), WIDX_W = $clog2(MAX_WORDS);
  localparam int SIZE_W = $clog2(MAX_WORDS + 1), TAG_W = SLOT_W + WIDX_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [ADDR_W-1:0] req_base_i = '0;
  logic [SIZE_W-1:0] req_size_i = SIZE_W'(1);
  logic [CNT_W-1:0]  req_count_i = '0;
  logic mem_req_valid_o, mem_req_ready_i;
  logic [ADDR_W-1:0] mem_req_addr_o;
  logic [TAG_W-1:0]  mem_req_tag_o;
  logic mem_rsp_valid_i;
  logic [TAG_W-1:0]  mem_rsp_tag_i;
  logic [DATA_W-1:0] mem_rsp_data_i;
  logic out_valid_o, out_ready_i, out_last_o, done_o;
  logic [CNT_W-1:0]  out_rec_o;
  logic [WIDX_W-1:0] out_word_o;
  logic [DATA_W-1:0] out_data_o;

  urf_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SLOTS(SLOTS),
               .MAX_WORDS(MAX_WORDS)) i_urf_engine (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  int checks = 0, errors = 0;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [SIZE_W-1:0] size;
    logic [CNT_W-1:0]  count;
  } req_t;
  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
  } rd_t;

  req_t sb_q[$];
  rd_t  pend[$];

  // stimulus modes: 0 in order, 1 newest first, 2 record 0 last, 3 random
  int rsp_mode = 0;
  bit rsp_hold = 0, mrdy_rand = 0, ordy_rand = 0, ordy_low = 0;

  // monitor state
  int unsigned cur_base = 0;
  int cur_size = 1, cur_count = 0, issued = 0, recs_seen = 0, exp_word = 0, cur_rec = 0, first_rec = -1;
  logic [ADDR_W-1:0] exp_addr = '0;
  bit seen [64];
  bit exp_done = 0, prev_ostall = 0, prev_mstall = 0;
  logic [DATA_W-1:0] p_data;
  logic [CNT_W-1:0]  p_rec;
  logic [WIDX_W-1:0] p_word;
  logic              p_last;
  logic [ADDR_W-1:0] p_addr;
  logic [TAG_W-1:0]  p_tag;

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory responder and ready drivers, changed just after each rising edge
  initial begin
    mem_req_ready_i = 1'b1;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_tag_i   = '0;
    mem_rsp_data_i  = '0;
    out_ready_i     = 1'b1;
    forever begin
      int idx;
      @(posedge clk_i); #1;
      mem_rsp_valid_i = 1'b0;
      mem_req_ready_i = mrdy_rand ? 1'($urandom_range(1, 0)) : 1'b1;
      out_ready_i     = ordy_low ? 1'b0 : (ordy_rand ? ($urandom_range(2, 0) != 0) : 1'b1);
      idx = -1;
      if (!rsp_hold && pend.size() > 0) begin
        case (rsp_mode)
          1: idx = pend.size() - 1;
          2: begin
            for (int k = pend.size() - 1; k >= 0; k--)
              if (int'(pend[k].addr - cur_base) >= cur_size) idx = k;
            if (idx < 0 && issued == cur_count * cur_size) idx = 0;
          end
          3: if ($urandom_range(1, 0) != 0) idx = $urandom_range(pend.size() - 1, 0);
          default: idx = 0;
        endcase
      end
      if (idx >= 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_tag_i   = pend[idx].tag;
        mem_rsp_data_i  = mem_word(pend[idx].addr);
        pend.delete(idx);
      end
    end
  end

  // scoreboard monitor, samples on the falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (exp_done) begin
        check(done_o == 1'b1, "R9", "done pulse", done_o, 1);
        exp_done = 0;
        if (sb_q.size() > 0) begin
          check(recs_seen == cur_count, "R3", "records delivered", recs_seen, cur_count);
          void'(sb_q.pop_front());
        end
      end else if (done_o) begin
        check(0, "R9", "done without completion", 1, 0);
      end

      if (req_valid_i && req_ready_o && sb_q.size() > 0) begin
        cur_base  = sb_q[0].base;
        cur_size  = int'(sb_q[0].size);
        cur_count = int'(sb_q[0].count);
        exp_addr  = sb_q[0].base;
        issued = 0; recs_seen = 0; exp_word = 0; first_rec = -1;
        for (int k = 0; k < 64; k++) seen[k] = 0;
        if (cur_count == 0) exp_done = 1;
      end

      if (req_ready_o && (out_valid_o || mem_req_valid_o))
        check(0, "R2", "ready while busy", 1, 0);

      if (prev_mstall)
        check(mem_req_valid_o && mem_req_addr_o == p_addr && mem_req_tag_o == p_tag,
              "R10", "stalled read changed", longint'(mem_req_addr_o), longint'(p_addr));
      if (mem_req_valid_o && mem_req_ready_i) begin
        check(mem_req_addr_o == exp_addr, "R3", "read address",
              longint'(mem_req_addr_o), longint'(exp_addr));
        check(int'(mem_req_tag_o[WIDX_W-1:0]) == int'(mem_req_addr_o - cur_base) % cur_size,
              "R3", "tag word field", mem_req_tag_o[WIDX_W-1:0],
              int'(mem_req_addr_o - cur_base) % cur_size);
        pend.push_back('{mem_req_tag_o, mem_req_addr_o});
        exp_addr = exp_addr + 1;
        issued++;
      end
      prev_mstall = mem_req_valid_o && !mem_req_ready_i;
      p_addr = mem_req_addr_o;
      p_tag  = mem_req_tag_o;

      if (prev_ostall)
        check(out_valid_o && out_data_o == p_data && out_rec_o == p_rec && out_word_o == p_word
              && out_last_o == p_last, "R8", "stalled beat changed",
              longint'(out_data_o), longint'(p_data));
      if (out_valid_o && out_ready_i) begin
        if (exp_word == 0) begin
          check(int'(out_rec_o) < cur_count && int'(out_rec_o) < 64 && !seen[int'(out_rec_o) % 64],
                "R3", "fresh record index", out_rec_o, cur_count);
          seen[int'(out_rec_o) % 64] = 1;
          cur_rec = int'(out_rec_o);
          if (first_rec < 0) first_rec = cur_rec;
        end else begin
          check(int'(out_rec_o) == cur_rec, "R6", "records interleaved", out_rec_o, cur_rec);
        end
        check(int'(out_word_o) == exp_word, "R4", "word order", out_word_o, exp_word);
        check(out_data_o == mem_word(ADDR_W'(cur_base + out_rec_o * cur_size + out_word_o)),
              "R4", "beat data", longint'(out_data_o),
              longint'(mem_word(ADDR_W'(cur_base + out_rec_o * cur_size + out_word_o))));
        check(out_last_o == (int'(out_word_o) == cur_size - 1), "R4", "last flag",
              out_last_o, int'(out_word_o) == cur_size - 1);
        if (exp_word == cur_size - 1) begin
          exp_word = 0;
          recs_seen++;
          if (recs_seen == cur_count) exp_done = 1;
        end else begin
          exp_word++;
        end
      end
      prev_ostall = out_valid_o && !out_ready_i;
      p_data = out_data_o; p_rec = out_rec_o; p_word = out_word_o; p_last = out_last_o;
    end
  end

  // driver: push the expected request, then present it
  task automatic run_req(input int base, input int size, input int count);
    req_t r;
    r.base = ADDR_W'(base); r.size = SIZE_W'(size); r.count = CNT_W'(count);
    sb_q.push_back(r);
    @(posedge clk_i); #1;
    while (!req_ready_o) begin @(posedge clk_i); #1; end
    req_valid_i = 1'b1;
    req_base_i  = r.base;
    req_size_i  = r.size;
    req_count_i = r.count;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    while (sb_q.size() > 0) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o == 1'b1, "R1", "reset req_ready", req_ready_o, 1);
    check(out_valid_o == 1'b0, "R1", "reset out_valid", out_valid_o, 0);
    check(mem_req_valid_o == 1'b0, "R1", "reset mem_req_valid", mem_req_valid_o, 0);
    check(done_o == 1'b0, "R1", "reset done", done_o, 0);

    // R2 / R3 / R4: in-order responses
    rsp_mode = 0;
    run_req(100, 4, 5);
    @(negedge clk_i);
    check(req_ready_o == 1'b0, "R2", "busy after accept", req_ready_o, 0);
    wait_done();

    // newest-first responses with output backpressure
    rsp_mode = 1; ordy_rand = 1;
    run_req(2000, 3, 6);
    wait_done();
    ordy_rand = 0;

    // R5: record 0 answered last, a later record must leave first
    rsp_mode = 2;
    run_req(500, 4, 3);
    wait_done();
    check(first_rec != 0, "R5", "first record out", first_rec, 1);

    // R7: no responses, issue stops at the slot limit
    rsp_mode = 0; rsp_hold = 1;
    run_req(40, 3, 6);
    repeat (100) @(negedge clk_i);
    check(issued == SLOTS * 3, "R7", "reads in flight", issued, SLOTS * 3);
    check(out_valid_o == 1'b0, "R7", "no beat without data", out_valid_o, 0);
    rsp_hold = 0;
    wait_done();

    // R8: output stalled, reads still fill every free slot
    ordy_low = 1;
    run_req(300, 2, 8);
    repeat (100) @(negedge clk_i);
    check(issued == SLOTS * 2, "R8", "reads during stall", issued, SLOTS * 2);
    check(out_valid_o == 1'b1, "R8", "beat held during stall", out_valid_o, 1);
    ordy_low = 0;
    wait_done();

    // R10 and random order at both size limits
    rsp_mode = 3; mrdy_rand = 1; ordy_rand = 1;
    run_req(7000, MAX_WORDS, 10);
    wait_done();
    run_req(9000, 1, 7);
    wait_done();
    rsp_mode = 0; mrdy_rand = 0; ordy_rand = 0;

    // R9: empty request
    run_req(64, 4, 0);
    wait_done();
    check(issued == 0, "R9", "reads for empty request", issued, 0);
    @(negedge clk_i);
    check(done_o == 1'b0, "R9", "done lasts one cycle", done_o, 0);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete actual=timeout expected=done");
    finish_run();
  end
endmodule